// File: doc/BRIEF.md
# SIMD Predicate Mask Stack

This block holds the per-lane execution mask for a 16-lane SIMD unit that runs divergent conditional code without any per-lane branch. A vector compare outside the block produces one condition bit per lane. A sequencer then drives a small command set: save the current mask, narrow it for the taken side, narrow it for the not-taken side, and restore it. The registered lane mask gates register writes, stores and memory or texture fetches, so lanes that are switched off have no side effects.

Both sides of a region run one after the other. The true and false checks are independent tests, not an if/else pair. Two combinational summaries tell the sequencer whether any lane would run each side, so it can skip a side that no lane would run. Nesting uses a stack of saved masks whose depth is a parameter. Loops use the same save, narrow and restore primitives.

Top module: `simd_mask_stack`

## Requirements
- R1: After synchronous reset, lane_mask_o is all ones, the stack holds no entries, and overflow_o and underflow_o are low.
- R2: Command code 1 (push) copies lane_mask_o onto the stack and leaves lane_mask_o unchanged.
- R3: A push when the stack already holds DEPTH entries leaves the stack contents and lane_mask_o unchanged. overflow_o is high for exactly the cycle after that command.
- R4: Command code 2 (take the true side) loads lane_mask_o with base AND cond_i. The base is the stack's top entry, or the current lane_mask_o when the stack is empty.
- R5: Command code 3 (take the false side) loads lane_mask_o with base AND NOT cond_i, using the same base as R4.
- R6: The true and false masks are both formed from the saved base, not from the already narrowed mask, so running one side after the other covers both halves of the base.
- R7: Command code 4 (pop) restores the top entry into lane_mask_o and removes that entry.
- R8: A pop on an empty stack leaves lane_mask_o unchanged. underflow_o is high for exactly the cycle after that command.
- R9: any_true_o is the OR of (base AND cond_i) and any_false_o is the OR of (base AND NOT cond_i). Both are combinational and valid in the cycle cond_i is presented.
- R10: Command code 0 (idle) and codes 5 to 7 leave lane_mask_o and the stack unchanged.
- R11: Saved masks come back in last-in, first-out order across up to DEPTH nested levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command: 0 idle, 1 push, 2 true side, 3 false side, 4 pop |
| cond_i | input | LANES | Per-lane compare result |
| lane_mask_o | output | LANES | Registered active lane mask |
| any_true_o | output | 1 | Some base lane has its condition set |
| any_false_o | output | 1 | Some base lane has its condition clear |
| overflow_o | output | 1 | One-cycle pulse after a push on a full stack |
| underflow_o | output | 1 | One-cycle pulse after a pop on an empty stack |

## Verification
The assertions take one command per cycle from the 3-bit code and take cond_i as a stable, known value wherever that command samples it. They also take unused codes to mean idle. The stimulus changes cmd_i and cond_i only on the falling clock edge. It uses each of the five defined codes and deliberately drives a full stack and an empty stack, so the overflow and underflow paths run inside the states the properties describe.

// File: rtl/mstk_pkg.sv
package mstk_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_PUSH  = 3'd1,
    CMD_TRUE  = 3'd2,
    CMD_FALSE = 3'd3,
    CMD_POP   = 3'd4
  } mstk_cmd_e;
endpackage

// File: rtl/mstk_store.sv
// Saved-mask storage: write port indexed by fill level, read of top entry.
module mstk_store #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    top_o,
  output logic [LVLW-1:0] level_o,
  output logic            empty_o,
  output logic            full_o,
  output logic            ovf_o,
  output logic            unf_o
);
  logic [W-1:0]    mem [DEPTH];
  logic [LVLW-1:0] level_q;
  logic            push_ok, pop_ok;
  logic [AW-1:0]   wr_idx, rd_idx;

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LVLW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign wr_idx  = AW'(level_q);
  assign rd_idx  = AW'(level_q - LVLW'(1));
  assign top_o   = mem[rd_idx];
  assign level_o = level_q;

  // No reset on the array so it maps onto plain RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      ovf_o <= push_i && full_o;
      unf_o <= pop_i && empty_o;
      if (push_ok)     level_q <= level_q + LVLW'(1);
      else if (pop_ok) level_q <= level_q - LVLW'(1);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (push_i && full_o) |=> ($stable(level_o) && ovf_o));
  assert_pop_level_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !empty_o) |=> (level_o == $past(level_o) - LVLW'(1)));
  assert_level_bound_R11: assert property (@(posedge clk) disable iff (rst)
    level_o <= LVLW'(DEPTH));
endmodule

// File: rtl/mstk_narrow.sv
// Base selection, narrowed masks and per-side lane summaries.
module mstk_narrow #(
  parameter int W = 16
) (
  input  logic [W-1:0] active_i,
  input  logic [W-1:0] top_i,
  input  logic         empty_i,
  input  logic [W-1:0] cond_i,
  output logic [W-1:0] base_o,
  output logic [W-1:0] true_mask_o,
  output logic [W-1:0] false_mask_o,
  output logic         any_true_o,
  output logic         any_false_o
);
  always_comb begin
    base_o       = empty_i ? active_i : top_i;
    true_mask_o  = base_o & cond_i;
    false_mask_o = base_o & ~cond_i;
    any_true_o   = |true_mask_o;
    any_false_o  = |false_mask_o;
  end
endmodule

// File: rtl/simd_mask_stack.sv
module simd_mask_stack #(
  parameter int LANES = 16,
  parameter int DEPTH = 8,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd_i,
  input  logic [LANES-1:0] cond_i,
  output logic [LANES-1:0] lane_mask_o,
  output logic             any_true_o,
  output logic             any_false_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  import mstk_pkg::*;

  mstk_cmd_e        cmd;
  logic             do_push, do_pop, do_true, do_false;
  logic [LANES-1:0] top, base, t_mask, f_mask;
  logic [LVLW-1:0]  level;
  logic             empty, full;

  assign cmd      = mstk_cmd_e'(cmd_i);
  assign do_push  = (cmd == CMD_PUSH);
  assign do_pop   = (cmd == CMD_POP);
  assign do_true  = (cmd == CMD_TRUE);
  assign do_false = (cmd == CMD_FALSE);

  mstk_store #(.W(LANES), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .push_i(do_push), .pop_i(do_pop),
    .wdata_i(lane_mask_o), .top_o(top), .level_o(level),
    .empty_o(empty), .full_o(full), .ovf_o(overflow_o), .unf_o(underflow_o)
  );

  mstk_narrow #(.W(LANES)) narrow_i (
    .active_i(lane_mask_o), .top_i(top), .empty_i(empty), .cond_i(cond_i),
    .base_o(base), .true_mask_o(t_mask), .false_mask_o(f_mask),
    .any_true_o(any_true_o), .any_false_o(any_false_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_mask_o <= '1;
    end else begin
      if (do_true)                lane_mask_o <= t_mask;
      else if (do_false)          lane_mask_o <= f_mask;
      else if (do_pop && !empty)  lane_mask_o <= top;
    end
  end

  assert_push_hold_R2: assert property (@(posedge clk) disable iff (rst)
    do_push |=> $stable(lane_mask_o));
  assert_true_subset_R4: assert property (@(posedge clk) disable iff (rst)
    do_true |=> ((lane_mask_o & ~$past(base)) == '0));
  assert_false_disjoint_R5: assert property (@(posedge clk) disable iff (rst)
    do_false |=> ((lane_mask_o & $past(cond_i)) == '0));
  assert_pop_restore_R7: assert property (@(posedge clk) disable iff (rst)
    (do_pop && !empty) |=> (lane_mask_o == $past(top)));
  assert_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (do_pop && empty) |=> ($stable(lane_mask_o) && underflow_o));
  assert_skip_side_R9: assert property (@(posedge clk) disable iff (rst)
    (do_true && !any_true_o) |=> (lane_mask_o == '0));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!do_push && !do_pop && !do_true && !do_false) |=> $stable(lane_mask_o));
  assert_no_dual_fault_R3: assert property (@(posedge clk) disable iff (rst)
    !(overflow_o && underflow_o));
endmodule

// File: tb/simd_mask_stack_tb.sv
module simd_mask_stack_tb_top;
  localparam int LANES = 16;
  localparam int DEPTH = 8;
  localparam int NVEC  = 13;

  logic             clk = 1'b0;
  logic             rst;
  logic [2:0]       cmd_i;
  logic [LANES-1:0] cond_i;
  logic [LANES-1:0] lane_mask_o;
  logic             any_true_o, any_false_o, overflow_o, underflow_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  simd_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .cond_i(cond_i),
    .lane_mask_o(lane_mask_o), .any_true_o(any_true_o),
    .any_false_o(any_false_o), .overflow_o(overflow_o),
    .underflow_o(underflow_o)
  );

  // {cmd, cond, expected mask after edge, any_true, any_false, underflow}
  localparam logic [37:0] VEC [NVEC] = '{
    {3'd0, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 1'b0},
    {3'd1, 16'h00FF, 16'hFFFF, 1'b1, 1'b1, 1'b0},
    {3'd2, 16'h00FF, 16'h00FF, 1'b1, 1'b1, 1'b0},
    {3'd3, 16'h00FF, 16'hFF00, 1'b1, 1'b1, 1'b0}, // R6 complement of base
    {3'd1, 16'h0F0F, 16'hFF00, 1'b1, 1'b1, 1'b0}, // R11 second level
    {3'd2, 16'h0F0F, 16'h0F00, 1'b1, 1'b1, 1'b0},
    {3'd3, 16'h0F0F, 16'hF000, 1'b1, 1'b1, 1'b0},
    {3'd2, 16'h00FF, 16'h0000, 1'b0, 1'b1, 1'b0},
    {3'd4, 16'h0000, 16'hFF00, 1'b0, 1'b1, 1'b0},
    {3'd0, 16'h1234, 16'hFF00, 1'b1, 1'b1, 1'b0},
    {3'd4, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0},
    {3'd4, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1},
    {3'd0, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1:    return "R2 push";
      3'd2:    return "R4 true side";
      3'd3:    return "R5 false side";
      3'd4:    return "R7/R8 pop";
      default: return "R10 idle";
    endcase
  endfunction

  // Drive at the falling edge, sample summaries, then sample state after the rise.
  task automatic step(input logic [2:0] c, input logic [15:0] cond);
    @(negedge clk);
    cmd_i  = c;
    cond_i = cond;
    #1;
    @(posedge clk);
    #1;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; cmd_i = 3'd0; cond_i = '0;
    @(posedge clk); @(posedge clk);
    #1;
    check(lane_mask_o == 16'hFFFF, "R1 mask", 32'(lane_mask_o), 32'hFFFF);
    check(!overflow_o && !underflow_o, "R1 flags",
          {30'd0, overflow_o, underflow_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cmd_i = '0; cond_i = '0;
    apply_reset();

    // Table walk: R9 summaries before the edge, mask and flags after it.
    for (int i = 0; i < NVEC; i++) begin
      logic [37:0] v;
      v = VEC[i];
      @(negedge clk);
      cmd_i  = v[37:35];
      cond_i = v[34:19];
      #1;
      check(any_true_o == v[2], "R9 any_true", 32'(any_true_o), 32'(v[2]));
      check(any_false_o == v[1], "R9 any_false", 32'(any_false_o), 32'(v[1]));
      @(posedge clk);
      #1;
      check(lane_mask_o == v[18:3], tag_of(v[37:35]), 32'(lane_mask_o), 32'(v[18:3]));
      check(underflow_o == v[0], "R8 underflow", 32'(underflow_o), 32'(v[0]));
    end

    // Unused code acts as idle (R10).
    step(3'd2, 16'hA5A5);
    step(3'd6, 16'h0000);
    check(lane_mask_o == 16'hA5A5, "R10 unused code", 32'(lane_mask_o), 32'hA5A5);

    // Empty-stack base is the active mask (R4).
    apply_reset();
    step(3'd2, 16'h0001);
    check(lane_mask_o == 16'h0001, "R4 empty base", 32'(lane_mask_o), 32'h0001);

    // Fill to DEPTH with distinct saved masks, then overflow (R3) and LIFO (R11).
    apply_reset();
    for (int k = 0; k < DEPTH; k++) begin
      step(3'd1, 16'h0000);
      step(3'd2, 16'hFFFF >> (k + 1));
    end
    check(lane_mask_o == (16'hFFFF >> DEPTH), "R4 nested narrow",
          32'(lane_mask_o), 32'(16'hFFFF >> DEPTH));
    step(3'd1, 16'h0000);
    check(overflow_o == 1'b1, "R3 overflow pulse", 32'(overflow_o), 32'd1);
    check(lane_mask_o == (16'hFFFF >> DEPTH), "R3 mask kept",
          32'(lane_mask_o), 32'(16'hFFFF >> DEPTH));
    step(3'd0, 16'h0000);
    check(overflow_o == 1'b0, "R3 pulse ends", 32'(overflow_o), 32'd0);
    for (int j = 0; j < DEPTH; j++) begin
      step(3'd4, 16'h0000);
      check(lane_mask_o == (16'hFFFF >> (DEPTH - 1 - j)), "R11 pop order",
            32'(lane_mask_o), 32'(16'hFFFF >> (DEPTH - 1 - j)));
    end
    step(3'd4, 16'h0000);
    check(underflow_o == 1'b1, "R8 underflow after drain", 32'(underflow_o), 32'd1);
    check(lane_mask_o == 16'hFFFF, "R8 mask kept", 32'(lane_mask_o), 32'hFFFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule